// File: doc/BRIEF.md
# Grouped Interrupt Acknowledge Controller

This block arbitrates among a set of level-sensitive interrupt lines for one processor. Each line carries an 8-bit priority and a one-bit group tag. A line is pending while its source is high and it is not already being serviced. The block raises one interrupt request toward the processor when the best pending line outranks everything currently in service. A global mask input can hold that request low.

Software-facing traffic is modelled as plain ports, with one set per group. An acknowledge read returns the ID of the winning line and makes that line active on the same clock edge. A query port returns the ID that an acknowledge would return, and reading it changes nothing. An end-of-interrupt write retires an active line.

The acknowledge checks the group and tolerates races. It returns the reserved spurious ID 1023 in two cases: when the overall winner belongs to the other group, and when the source dropped before the read. In both cases it changes no state. Pending and active state are visible as bit vectors, so software can compare them before and after an acknowledge.

Top module: `grp_ack_ctrl`

## Requirements
- R1: After reset no line is active, `irq` is low, and with all sources low both query ports and both acknowledge ports read 1023.
- R2: While a group's acknowledge read strobe is high, its ID port shows the winning line's index, zero-extended to 10 bits, if the winner belongs to that group. On the next clock edge that line's bit in `act_vec` is set and its `pend_vec` bit reads 0. While the strobe is low the port reads 1023.
- R3: The winner is the pending line with the numerically lowest priority. When priorities are equal, the lower line index wins.
- R4: If the overall winner belongs to the other group, an acknowledge and a query for a group both read 1023. That acknowledge changes no active state.
- R5: A line whose source is low is not pending. An acknowledge issued in the same cycle as the drop reads 1023 and leaves `act_vec` unchanged.
- R6: The query port of each group reads the same value that the group's acknowledge would read. Holding it for any number of cycles leaves `pend_vec` and `act_vec` unchanged.
- R7: An end-of-interrupt write on a group's port clears `act_vec` bit `id`, provided that line is active and belongs to that group. Otherwise the write is ignored.
- R8: An active line takes no part in arbitration and reads 0 in `pend_vec` until it is retired, even while its source stays high.
- R9: `irq` is high exactly when `irq_mask` is low, a pending winner exists, and the winner's priority is numerically lower than that of every active line.
- R10: Bit i of `pend_vec` and bit i of `act_vec` describe line i. `pend_vec` equals `src_level` with the active lines removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_level | input | N_SRC | Level-sensitive interrupt sources |
| cfg_prio | input | N_SRC*PRIO_W | Priority of line i in bits [i*PRIO_W +: PRIO_W]; lower value wins |
| cfg_group | input | N_SRC | Group of each line (0 or 1) |
| irq_mask | input | 1 | Global suppression of `irq` |
| ack0_rd | input | 1 | Group 0 acknowledge read strobe |
| ack0_id | output | ID_W | Group 0 acknowledge result |
| ack1_rd | input | 1 | Group 1 acknowledge read strobe |
| ack1_id | output | ID_W | Group 1 acknowledge result |
| eoi0_wr | input | 1 | Group 0 end-of-interrupt write strobe |
| eoi0_id | input | ID_W | Group 0 end-of-interrupt ID |
| eoi1_wr | input | 1 | Group 1 end-of-interrupt write strobe |
| eoi1_id | input | ID_W | Group 1 end-of-interrupt ID |
| hppi0_id | output | ID_W | Group 0 highest pending query |
| hppi1_id | output | ID_W | Group 1 highest pending query |
| pend_vec | output | N_SRC | Per-line pending state |
| act_vec | output | N_SRC | Per-line active state |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is the race in which a source drops just as its acknowledge is issued. The bench first leaves the line asserted long enough to see it in the query port. It then lowers the source and raises the acknowledge strobe in the same cycle, and checks that the result is 1023 and that the active state does not move. The cross-group case is set up the same way. A higher-priority group 0 line is raised over group 1 lines that are already pending, and a group 1 acknowledge is issued at that moment.

// File: rtl/grp_ack_ctrl.sv
module grp_ack_ctrl #(
  parameter int N_SRC   = 8,
  parameter int PRIO_W  = 8,
  parameter int ID_W    = 10,
  parameter int SPUR_ID = 1023
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          src_level,
  input  logic [N_SRC*PRIO_W-1:0]   cfg_prio,
  input  logic [N_SRC-1:0]          cfg_group,
  input  logic                      irq_mask,
  input  logic                      ack0_rd,
  output logic [ID_W-1:0]           ack0_id,
  input  logic                      ack1_rd,
  output logic [ID_W-1:0]           ack1_id,
  input  logic                      eoi0_wr,
  input  logic [ID_W-1:0]           eoi0_id,
  input  logic                      eoi1_wr,
  input  logic [ID_W-1:0]           eoi1_id,
  output logic [ID_W-1:0]           hppi0_id,
  output logic [ID_W-1:0]           hppi1_id,
  output logic [N_SRC-1:0]          pend_vec,
  output logic [N_SRC-1:0]          act_vec,
  output logic                      irq
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam logic [ID_W-1:0] SPUR = ID_W'(SPUR_ID);

  logic [N_SRC-1:0]  act_q, pend, set_m, clr_m;
  logic              win_hit, run_hit;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio, run_prio;
  logic              g0_ok, g1_ok, eoi0_hit, eoi1_hit;
  logic [IDX_W-1:0]  e0_idx, e1_idx;

  assign pend = src_level & ~act_q;

  always_comb begin
    win_hit  = 1'b0;
    win_idx  = '0;
    win_prio = '1;
    run_hit  = 1'b0;
    run_prio = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && (!win_hit || cfg_prio[i*PRIO_W +: PRIO_W] < win_prio)) begin
        win_hit  = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = cfg_prio[i*PRIO_W +: PRIO_W];
      end
      if (act_q[i] && (!run_hit || cfg_prio[i*PRIO_W +: PRIO_W] < run_prio)) begin
        run_hit  = 1'b1;
        run_prio = cfg_prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign g0_ok    = win_hit && !cfg_group[win_idx];
  assign g1_ok    = win_hit &&  cfg_group[win_idx];
  assign hppi0_id = g0_ok ? ID_W'(win_idx) : SPUR;
  assign hppi1_id = g1_ok ? ID_W'(win_idx) : SPUR;
  assign ack0_id  = ack0_rd ? hppi0_id : SPUR;
  assign ack1_id  = ack1_rd ? hppi1_id : SPUR;
  assign irq      = !irq_mask && win_hit && (!run_hit || win_prio < run_prio);

  assign e0_idx   = eoi0_id[IDX_W-1:0];
  assign e1_idx   = eoi1_id[IDX_W-1:0];
  assign eoi0_hit = eoi0_wr && (eoi0_id < ID_W'(N_SRC)) && act_q[e0_idx] && !cfg_group[e0_idx];
  assign eoi1_hit = eoi1_wr && (eoi1_id < ID_W'(N_SRC)) && act_q[e1_idx] &&  cfg_group[e1_idx];

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if ((ack0_rd && g0_ok) || (ack1_rd && g1_ok)) set_m[win_idx] = 1'b1;
    if (eoi0_hit) clr_m[e0_idx] = 1'b1;
    if (eoi1_hit) clr_m[e1_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= (act_q | set_m) & ~clr_m;
  end

  assign pend_vec = pend;
  assign act_vec  = act_q;

  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0_rd && ack0_id != SPUR) |=> act_q[$past(win_idx)]); // R2
  AST_SPUR_ACK_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack1_rd && ack1_id == SPUR && !(ack0_rd && ack0_id != SPUR) && !eoi0_wr && !eoi1_wr)
      |=> $stable(act_q)); // R4
  AST_QUERY_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (hppi1_id != SPUR) |-> cfg_group[hppi1_id[IDX_W-1:0]]); // R4
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_vec != '0)); // R9
  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoi0_wr && !eoi1_wr) |=> ((act_q & $past(act_q)) == $past(act_q))); // R8
endmodule

// File: tb/sim_grp_ack_ctrl.sv
module sim_grp_ack_ctrl;
  localparam int N = 8;
  localparam logic [1023:0] DUMMY = '0;
  localparam logic [9:0] SP = 10'd1023;
  localparam logic [N*8-1:0] PRIO = {8'hFF, 8'hFF, 8'h40, 8'h80, 8'h10, 8'h20, 8'h20, 8'h40};
  localparam logic [N-1:0]   GRP  = 8'b1101_0110;

  // {src, ack0, ack1, exp ack0_id, exp ack1_id, exp act after edge}
  localparam int NV = 6;
  localparam logic [37:0] TBL [NV] = '{
    {8'h06, 1'b0, 1'b1, SP,    10'd1, 8'h02},
    {8'h06, 1'b0, 1'b1, SP,    10'd2, 8'h06},
    {8'h06, 1'b0, 1'b1, SP,    SP,    8'h06},
    {8'h0E, 1'b0, 1'b1, SP,    SP,    8'h06},
    {8'h0E, 1'b1, 1'b0, 10'd3, SP,    8'h0E},
    {8'h1E, 1'b0, 1'b1, SP,    10'd4, 8'h1E}
  };

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_level = '0;
  logic irq_mask = 0, ack0_rd = 0, ack1_rd = 0, eoi0_wr = 0, eoi1_wr = 0;
  logic [9:0] eoi0_id = '0, eoi1_id = '0;
  logic [9:0] ack0_id, ack1_id, hppi0_id, hppi1_id;
  logic [N-1:0] pend_vec, act_vec;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  grp_ack_ctrl #(.N_SRC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .src_level(src_level), .cfg_prio(PRIO), .cfg_group(GRP),
    .irq_mask(irq_mask), .ack0_rd(ack0_rd), .ack0_id(ack0_id), .ack1_rd(ack1_rd),
    .ack1_id(ack1_id), .eoi0_wr(eoi0_wr), .eoi0_id(eoi0_id), .eoi1_wr(eoi1_wr),
    .eoi1_id(eoi1_id), .hppi0_id(hppi0_id), .hppi1_id(hppi1_id), .pend_vec(pend_vec),
    .act_vec(act_vec), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; src_level = '0; ack0_rd = 0; ack1_rd = 0; eoi0_wr = 0; eoi1_wr = 0; irq_mask = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    ack0_rd = 0; ack1_rd = 0; eoi0_wr = 0; eoi1_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 act", act_vec, 0);
    chk("R1 irq", irq, 0);
    chk("R1 hppi0", hppi0_id, SP);
    chk("R1 hppi1", hppi1_id, SP);
    chk("R1 ack0", ack0_id, SP);
    chk("R1 ack1", ack1_id, SP);

    for (int k = 0; k < NV; k++) begin
      src_level = TBL[k][37:30];
      ack0_rd   = TBL[k][29];
      ack1_rd   = TBL[k][28];
      #1;
      chk($sformatf("R2 R3 R4 vec%0d ack0", k), ack0_id, TBL[k][27:18]);
      chk($sformatf("R2 R3 R4 vec%0d ack1", k), ack1_id, TBL[k][17:8]);
      tick();
      chk($sformatf("R2 R8 vec%0d act", k), act_vec, TBL[k][7:0]);
      chk($sformatf("R10 vec%0d pend", k), pend_vec, TBL[k][37:30] & ~TBL[k][7:0]);
    end

    // R4: group 0 winner over pending group 1 lines, group 1 query and ack spurious
    do_reset();
    src_level = 8'h0E; ack1_rd = 1; #1;
    chk("R4 hppi1", hppi1_id, SP);
    chk("R4 ack1", ack1_id, SP);
    chk("R6 hppi0", hppi0_id, 3);
    tick();
    chk("R4 act unchanged", act_vec, 0);
    chk("R4 pend unchanged", pend_vec, 8'h0E);

    // R5: drop the source in the same cycle as the acknowledge
    do_reset();
    src_level = 8'h01; #1;
    chk("R5 hppi0 before", hppi0_id, 0);
    chk("R9 irq idle", irq, 1);
    tick();
    src_level = 8'h00; ack0_rd = 1; #1;
    chk("R5 ack0 spurious", ack0_id, SP);
    tick();
    chk("R5 act unchanged", act_vec, 0);
    chk("R5 pend", pend_vec, 0);

    // R6: queries have no side effects
    src_level = 8'h01;
    repeat (3) tick();
    chk("R6 act", act_vec, 0);
    chk("R6 pend", pend_vec, 8'h01);
    chk("R6 hppi0", hppi0_id, 0);

    // R3: tie at priority 0x40 between line 0 and 5
    src_level = 8'h21; #1;
    chk("R3 tie", hppi0_id, 0);
    ack0_rd = 1; #1;
    chk("R2 ack0 tie", ack0_id, 0);
    tick();
    chk("R2 act", act_vec, 8'h01);

    // R9: equal priority does not preempt, strictly higher does, mask suppresses
    #1;
    chk("R9 equal prio", irq, 0);
    chk("R8 line5 next", hppi0_id, 5);
    src_level = 8'h29; #1;
    chk("R9 higher prio", irq, 1);
    irq_mask = 1; #1;
    chk("R9 masked", irq, 0);
    irq_mask = 0;

    // R8: active line 0 still asserted is not pending
    src_level = 8'h01; #1;
    chk("R8 pend", pend_vec, 0);
    chk("R8 hppi0", hppi0_id, SP);

    // R7: wrong group and non-active EOI ignored, then correct EOI
    eoi1_wr = 1; eoi1_id = 10'd0;
    tick();
    chk("R7 wrong group", act_vec, 8'h01);
    eoi0_wr = 1; eoi0_id = 10'd5;
    tick();
    chk("R7 not active", act_vec, 8'h01);
    eoi0_wr = 1; eoi0_id = 10'd0;
    tick();
    chk("R7 retire", act_vec, 0);
    chk("R10 pend back", pend_vec, 8'h01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule